// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block holds the configuration bytes of a PCI function that decide where two I/O address windows sit. One window is 128 bytes long and serves power management. The other is 16 bytes long and serves an SMBus host.

Software writes the configuration space one byte at a time and reads it back the same way. When a write lands on a base register or on the SMBus enable byte, the stored value is cut down to its legal form. Each window has its own enable bit, and the two bits sit at different offsets.

A separate I/O address input is compared against both windows at all times. When the address falls inside an enabled window, the block raises a hit, tells which window matched, and gives the offset of the address within that window. Bytes in the standard 64-byte header are not modelled here.

Top module: `io_window_decode`

## Requirements
- R1: While reset is low, every byte from 0x40 to 0xFF is cleared, except bytes 0x48 and 0x90, which read 0x01. Under this state neither window is enabled, so no I/O address hits.
- R2: The power-management base occupies bytes 0x48 to 0x4B.
  - A write of d to 0x48 stores (d & 0x80) | 0x01.
  - A write to 0x49 stores d unchanged.
  - Writes to 0x4A and 0x4B store 0x00.
- R3: The SMBus base occupies bytes 0x90 to 0x93.
  - A write of d to 0x90 stores (d & 0xF0) | 0x01.
  - A write to 0x91 stores d unchanged.
  - Writes to 0x92 and 0x93 store 0x00.
- R4: A write of d to byte 0xD2 stores d & 0x0F. Bit 0 of byte 0xD2 enables the SMBus window.
- R5: Bit 7 of byte 0x41 enables the power-management window. When that window is enabled and io_addr[15:7] equals {byte 0x49, bit 7 of byte 0x48}, the outputs are:
  - io_hit = 1
  - io_sel = 0
  - io_offset = io_addr[6:0]
- R6: When the SMBus window is enabled and io_addr[15:4] equals {byte 0x91, bits 7:4 of byte 0x90}, and the power-management window does not also match, the outputs are:
  - io_hit = 1
  - io_sel = 1
  - io_offset = {3'b000, io_addr[3:0]}
- R7: An address outside both windows gives io_hit = 0, io_sel = 0 and io_offset = 0. So does an address inside a window whose enable bit is clear.
- R8: When both enabled windows match the same address, the power-management window wins.
- R9: Bytes 0x40 to 0xFF that are not named above read back exactly as written. Header bytes 0x00 to 0x3F always read 0x00, and writes to them are ignored.
- R10: A configuration write takes effect on the rising clock edge that ends its cycle. During the write cycle itself, the decode still reflects the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored byte at cfg_addr |
| io_addr | input | IO_W | I/O address being decoded |
| io_hit | output | 1 | Address falls in an enabled window |
| io_sel | output | 1 | 0 for the power-management window, 1 for the SMBus window |
| io_offset | output | 7 | Offset of the address within the matched window |

## Verification
The hardest situation to reach is the overlap case. Both bases must be steered to the same 128-byte region, with SMBus alignment inside it, and both enables set at once. The stimulus reaches it by writing the SMBus base into the power-management range. It then drops the power-management enable and shows that the same address falls through to the SMBus window. The one-cycle lag of R10 is checked by sampling the decode in the same cycle as the enabling write.

// File: rtl/io_window_decode.sv
module io_window_decode #(
  parameter int IO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [7:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  output logic [7:0]      cfg_rdata,
  input  logic [IO_W-1:0] io_addr,
  output logic            io_hit,
  output logic            io_sel,
  output logic [6:0]      io_offset
);
  localparam int PM_LOG  = 7;
  localparam int SMB_LOG = 4;
  localparam int DEPTH   = 192;

  logic [7:0] cfg [0:DEPTH-1];
  logic [7:0] idx;
  logic       above;

  assign idx   = cfg_addr - 8'd64;
  assign above = cfg_addr[7:6] != 2'b00;

  function automatic logic [7:0] legalize(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h48:                      return {d[7], 6'b0, 1'b1};
      8'h90:                      return {d[7:4], 3'b0, 1'b1};
      8'h4A, 8'h4B, 8'h92, 8'h93: return 8'h00;
      8'hD2:                      return {4'b0, d[3:0]};
      default:                    return d;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        cfg[i] <= (i == 8 || i == 80) ? 8'h01 : 8'h00;
    end else if (cfg_wr && above) begin
      cfg[idx] <= legalize(cfg_addr, cfg_wdata);
    end
  end

  assign cfg_rdata = above ? cfg[idx] : 8'h00;

  logic [IO_W-1:0] pm_base, smb_base;
  logic            pm_hit, smb_hit;

  assign pm_base  = IO_W'({cfg[9],  cfg[8][7],    7'b0});
  assign smb_base = IO_W'({cfg[81], cfg[80][7:4], 4'b0});

  assign pm_hit  = cfg[1][7]   && (io_addr[IO_W-1:PM_LOG]  == pm_base[IO_W-1:PM_LOG]);
  assign smb_hit = cfg[146][0] && (io_addr[IO_W-1:SMB_LOG] == smb_base[IO_W-1:SMB_LOG]);

  assign io_hit    = pm_hit || smb_hit;
  assign io_sel    = !pm_hit && smb_hit;
  assign io_offset = pm_hit  ? io_addr[6:0] :
                     smb_hit ? {3'b000, io_addr[3:0]} : 7'd0;
endmodule

module io_window_decode_chk #(
  parameter int IO_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      cfg_addr,
  input logic [7:0]      cfg_rdata,
  input logic [IO_W-1:0] io_addr,
  input logic            io_hit,
  input logic            io_sel,
  input logic [6:0]      io_offset
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !io_hit);

  a_r2_pm_low_form: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == 8'h48 |-> (cfg_rdata[0] && cfg_rdata[6:1] == 6'd0));

  a_r3_smb_low_form: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == 8'h90 |-> (cfg_rdata[0] && cfg_rdata[3:1] == 3'd0));

  a_r4_enable_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr == 8'hD2 |-> cfg_rdata[7:4] == 4'd0);

  a_r5_pm_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit && !io_sel) |-> io_offset == io_addr[6:0]);

  a_r6_smb_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit && io_sel) |-> io_offset == {3'b000, io_addr[3:0]});

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !io_hit |-> (!io_sel && io_offset == 7'd0));

  a_r9_header_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr[7:6] == 2'b00 |-> cfg_rdata == 8'h00);
endmodule

bind io_window_decode io_window_decode_chk #(.IO_W(IO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .io_addr(io_addr), .io_hit(io_hit), .io_sel(io_sel), .io_offset(io_offset)
);

// File: tb/io_window_decode_test.sv
module io_window_decode_test;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [7:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [7:0]  cfg_rdata;
  logic [15:0] io_addr = 0;
  logic        io_hit, io_sel;
  logic [6:0]  io_offset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    bit          is_io;
    logic [8:0]  exp;
    string       req;
  } item_t;

  item_t q[$];

  io_window_decode uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
    .io_hit(io_hit), .io_sel(io_sel), .io_offset(io_offset)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [8:0] got;
        it = q.pop_front();
        got = it.is_io ? {io_hit, io_sel, io_offset} : {1'b0, cfg_rdata};
        total++;
        if (got !== it.exp) begin
          bad++;
          $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string r);
    @(negedge clk);
    cfg_addr = a;
    q.push_back('{is_io: 1'b0, exp: {1'b0, e}, req: r});
  endtask

  task automatic io(input logic [15:0] a, input bit h, input bit s,
                    input logic [6:0] o, input string r);
    @(negedge clk);
    io_addr = a;
    q.push_back('{is_io: 1'b1, exp: {h, s, o}, req: r});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rd(8'h48, 8'h01, "R1");
    rd(8'h90, 8'h01, "R1");
    rd(8'h41, 8'h00, "R1");
    rd(8'hD2, 8'h00, "R1");
    io(16'h0000, 0, 0, 0, "R1");
    rst_n = 1;
    rd(8'h60, 8'h00, "R1");

    wr(8'h60, 8'hA5); rd(8'h60, 8'hA5, "R9");
    wr(8'h10, 8'hFF); rd(8'h10, 8'h00, "R9");

    wr(8'h48, 8'hFF); rd(8'h48, 8'h81, "R2");
    wr(8'h49, 8'h12); rd(8'h49, 8'h12, "R2");
    wr(8'h4A, 8'h77); rd(8'h4A, 8'h00, "R2");
    wr(8'h4B, 8'h66); rd(8'h4B, 8'h00, "R2");

    io(16'h1285, 0, 0, 0, "R7");
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 8'h41; cfg_wdata = 8'h80;
    q.push_back('{is_io: 1'b1, exp: 9'h000, req: "R10"});
    @(negedge clk);
    cfg_wr = 0;
    io(16'h1285, 1, 0, 7'h05, "R5");
    io(16'h12FF, 1, 0, 7'h7F, "R5");
    io(16'h1300, 0, 0, 0, "R7");
    io(16'h127F, 0, 0, 0, "R7");

    wr(8'h90, 8'hFF); rd(8'h90, 8'hF1, "R3");
    wr(8'h91, 8'h34); rd(8'h91, 8'h34, "R3");
    wr(8'h92, 8'h55); rd(8'h92, 8'h00, "R3");
    io(16'h34F7, 0, 0, 0, "R7");
    wr(8'hD2, 8'hFF); rd(8'hD2, 8'h0F, "R4");
    io(16'h34F7, 1, 1, 7'h07, "R6");
    io(16'h3500, 0, 0, 0, "R7");

    wr(8'h90, 8'h90); wr(8'h91, 8'h12);
    io(16'h1295, 1, 0, 7'h15, "R8");
    wr(8'h41, 8'h00);
    io(16'h1295, 1, 1, 7'h05, "R8");
    io(16'h1285, 0, 0, 0, "R7");
    wr(8'hD2, 8'hF0); rd(8'hD2, 8'h00, "R4");
    io(16'h1295, 0, 0, 0, "R4");

    @(negedge clk); rst_n = 0;
    rd(8'h60, 8'h00, "R1");
    rd(8'h49, 8'h00, "R1");
    rd(8'h48, 8'h01, "R1");
    @(negedge clk); @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule